// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block sequences one conversion cycle of a successive-approximation analog-to-digital converter in normal (one-shot) mode. It counts system clocks through up to four phases: a short trigger response, converter stabilization, the active conversion window, and a post-conversion wait. The end-of-conversion interrupt is a one-clock pulse that follows the wait, not the conversion. The analog comparator, the approximation register and any reference checks sit outside; this block only tells them when to run.

A rising edge on the enable input starts a stabilization period, and conversion follows it automatically. After the interrupt the sequencer is idle but stays stabilized. From then on a software, external or timer trigger starts a conversion after a three-clock response delay. A 3-bit speed code selects the lengths of the stabilization, conversion and wait phases. A control-register write strobe or a trigger that arrives during a running cycle restarts it. A strobe that lands on the final stabilization clock inserts a fresh 64-clock stabilization period.

Top module: `adc_conv_sequencer`

## Requirements
- R1: After reset, phase_o is 0 and ana_en_o, busy_o and irq_o are low. The phase encoding is 0 idle, 1 trigger response, 2 stabilization, 3 conversion, 4 wait.
- R2: When en_i rises, stabilization lasts 13, 26 or 39 clocks for speed codes 0, 1 and 2, and 50 clocks for codes 3 to 7. Conversion then starts on its own. The interrupt comes 66, 131, 196, 259, 311, 363, 415 or 467 clocks after the edge that samples en_i high.
- R3: The conversion phase lasts 26×(n+1) clocks for speed code n. ana_en_o is high exactly while phase_o is 3.
- R4: The wait phase lasts one clock longer than the conversion phase. irq_o pulses for one clock as the wait ends, and phase_o returns to 0 on that same clock.
- R5: With en_i high and the sequencer idle, a pulse on trig_sw_i, trig_ext_i or trig_tmr_i gives a 3-clock response phase followed by conversion. The interrupt comes 3+conversion+wait clocks after the triggering edge.
- R6: A reg_wr_i pulse or a trigger during the response, conversion or wait phase restarts the cycle at the response phase. The aborted cycle raises no interrupt.
- R7: A reg_wr_i pulse or a trigger on the final clock of a stabilization period inserts a new 64-clock stabilization period. This repeats each time the conflict recurs.
- R8: A reg_wr_i pulse or a trigger during stabilization, but not on its final clock, has no effect on the timing.
- R9: A reg_wr_i pulse while idle starts nothing: phase_o stays 0 and no interrupt follows.
- R10: With en_i low, phase_o is 0 on the next clock and no interrupt is raised, even if one was pending.
- R11: The speed code is sampled when a cycle starts or restarts. Changes to spd_i in the middle of a cycle do not alter its timing.
- R12: busy_o is high whenever phase_o is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Converter enable; a rising edge starts stabilization |
| spd_i | input | 3 | Speed code selecting the phase lengths |
| trig_sw_i | input | 1 | Software trigger strobe |
| trig_ext_i | input | 1 | External trigger strobe |
| trig_tmr_i | input | 1 | Timer trigger strobe |
| reg_wr_i | input | 1 | Control-register write strobe |
| phase_o | output | 3 | Current phase code |
| ana_en_o | output | 1 | Analog conversion enable, high during conversion |
| busy_o | output | 1 | Cycle in progress |
| irq_o | output | 1 | One-clock end-of-conversion interrupt |

## Verification
The hardest case to reach is a strobe that lands exactly on the last stabilization clock, and more so a second one that lands on the last clock of the reinserted period. Random stimulus almost never hits either one. The bench reaches them by counting edges from the rising edge of enable and pulsing the write strobe on edge 14 and again on edge 78. It then checks the interrupt delay against totals computed from the phase lengths. The strobe is also placed one clock earlier, where it must have no effect. A fixed-seed random phase runs alongside, and a cycle-level model in the bench checks it on every clock.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_RESP = 3'd1,
      PH_STAB = 3'd2,
      PH_CONV = 3'd3,
      PH_WAIT = 3'd4
   } phase_e;
endpackage

// File: rtl/adc_seq_len.sv
module adc_seq_len #(
   parameter int SPD_W      = 3,
   parameter int CNT_W      = 8,
   parameter int CONV_UNIT  = 26,
   parameter int STAB_STEP  = 13,
   parameter int STAB_CAP   = 50,
   parameter int WAIT_EXTRA = 1
) (
   input  logic [SPD_W-1:0] code_new,
   input  logic [SPD_W-1:0] code_cur,
   output logic [CNT_W-1:0] stab_new,
   output logic [CNT_W-1:0] conv_cur,
   output logic [CNT_W-1:0] wait_cur
);
   localparam int CODES = 2 ** SPD_W;

   logic [CNT_W-1:0] stab_tab [CODES];
   logic [CNT_W-1:0] conv_tab [CODES];
   logic [CNT_W-1:0] wait_tab [CODES];

   for (genvar g = 0; g < CODES; g++) begin : g_code
      localparam int CONV_L   = CONV_UNIT * (g + 1);
      localparam int STAB_RAW = STAB_STEP * (g + 1);
      if (STAB_CAP > 0 && STAB_RAW > STAB_CAP) begin : g_cap
         assign stab_tab[g] = CNT_W'(STAB_CAP);
      end else begin : g_lin
         assign stab_tab[g] = CNT_W'(STAB_RAW);
      end
      assign conv_tab[g] = CNT_W'(CONV_L);
      assign wait_tab[g] = CNT_W'(CONV_L + WAIT_EXTRA);
   end

   assign stab_new = stab_tab[code_new];
   assign conv_cur = conv_tab[code_cur];
   assign wait_cur = wait_tab[code_cur];
endmodule

// File: rtl/adc_seq_evt.sv
module adc_seq_evt (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic trig_sw,
   input  logic trig_ext,
   input  logic trig_tmr,
   input  logic reg_wr,
   output logic trig_any,
   output logic evt_any,
   output logic en_rise
);
   logic en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= en;
   end

   assign trig_any = trig_sw | trig_ext | trig_tmr;
   assign evt_any  = trig_any | reg_wr;
   assign en_rise  = en & ~en_q;
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
   import adc_seq_pkg::*;
#(
   parameter int SPD_W      = 3,
   parameter int CNT_W      = 8,
   parameter int RESP_LEN   = 3,
   parameter int STAB_REINS = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             en_rise,
   input  logic             trig_any,
   input  logic             evt_any,
   input  logic [SPD_W-1:0] spd,
   input  logic [CNT_W-1:0] stab_new,
   input  logic [CNT_W-1:0] conv_cur,
   input  logic [CNT_W-1:0] wait_cur,
   output phase_e           ph,
   output logic [SPD_W-1:0] spd_q,
   output logic             irq
);
   localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
   localparam logic [CNT_W-1:0] RESP_M1  = CNT_W'(RESP_LEN - 1);
   localparam logic [CNT_W-1:0] REINS_M1 = CNT_W'(STAB_REINS - 1);

   logic [CNT_W-1:0] cnt;
   logic             cnt_zero;

   assign cnt_zero = (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph    <= PH_IDLE;
         cnt   <= '0;
         spd_q <= '0;
         irq   <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (!en) begin
            ph  <= PH_IDLE;
            cnt <= '0;
         end else begin
            case (ph)
               PH_IDLE: begin
                  if (en_rise) begin
                     ph    <= PH_STAB;
                     cnt   <= stab_new - ONE;
                     spd_q <= spd;
                  end else if (trig_any) begin
                     ph    <= PH_RESP;
                     cnt   <= RESP_M1;
                     spd_q <= spd;
                  end
               end
               PH_STAB: begin
                  if (cnt_zero) begin
                     if (evt_any) begin
                        cnt <= REINS_M1;
                     end else begin
                        ph  <= PH_CONV;
                        cnt <= conv_cur - ONE;
                     end
                  end else begin
                     cnt <= cnt - ONE;
                  end
               end
               PH_RESP, PH_CONV, PH_WAIT: begin
                  if (evt_any) begin
                     ph    <= PH_RESP;
                     cnt   <= RESP_M1;
                     spd_q <= spd;
                  end else if (cnt_zero) begin
                     if (ph == PH_RESP) begin
                        ph  <= PH_CONV;
                        cnt <= conv_cur - ONE;
                     end else if (ph == PH_CONV) begin
                        ph  <= PH_WAIT;
                        cnt <= wait_cur - ONE;
                     end else begin
                        ph  <= PH_IDLE;
                        irq <= 1'b1;
                     end
                  end else begin
                     cnt <= cnt - ONE;
                  end
               end
               default: begin
                  ph  <= PH_IDLE;
                  cnt <= '0;
               end
            endcase
         end
      end
   end

   // R4
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R4
   irq_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ($past(ph) == PH_WAIT && ph == PH_IDLE));

   // R10
   en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (ph == PH_IDLE && !irq));

   // R7
   reinsert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ph == PH_STAB && cnt_zero && evt_any) |=> (ph == PH_STAB && cnt == REINS_M1));

   // R5
   idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ph == PH_IDLE && !en_rise && trig_any) |=> (ph == PH_RESP));

   // R11
   spd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph != PH_IDLE && $past(ph) != PH_IDLE && $past(en) && !$past(evt_any)) |-> $stable(spd_q));
endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer
   import adc_seq_pkg::*;
#(
   parameter int SPD_W      = 3,
   parameter int CONV_UNIT  = 26,
   parameter int STAB_STEP  = 13,
   parameter int STAB_CAP   = 50,
   parameter int WAIT_EXTRA = 1,
   parameter int RESP_LEN   = 3,
   parameter int STAB_REINS = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [SPD_W-1:0] spd_i,
   input  logic             trig_sw_i,
   input  logic             trig_ext_i,
   input  logic             trig_tmr_i,
   input  logic             reg_wr_i,
   output logic [2:0]       phase_o,
   output logic             ana_en_o,
   output logic             busy_o,
   output logic             irq_o
);
   localparam int MAX_CONV = CONV_UNIT * (2 ** SPD_W) + WAIT_EXTRA;
   localparam int MAX_STAB = (STAB_CAP > 0) ? STAB_CAP : STAB_STEP * (2 ** SPD_W);
   localparam int MAX_A    = (MAX_CONV > MAX_STAB) ? MAX_CONV : MAX_STAB;
   localparam int MAX_B    = (STAB_REINS > RESP_LEN) ? STAB_REINS : RESP_LEN;
   localparam int MAX_LEN  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CNT_W    = $clog2(MAX_LEN + 1);

   if (SPD_W < 1 || SPD_W > 6) begin : g_bad_spd
      $error("SPD_W out of range");
   end
   if (RESP_LEN < 1 || STAB_REINS < 1 || CONV_UNIT < 1 || STAB_STEP < 1) begin : g_bad_len
      $error("phase lengths must be positive");
   end
   if (WAIT_EXTRA < 0) begin : g_bad_wait
      $error("WAIT_EXTRA must not be negative");
   end

   logic             trig_any, evt_any, en_rise, irq;
   logic [SPD_W-1:0] spd_q;
   logic [CNT_W-1:0] stab_new, conv_cur, wait_cur;
   phase_e           ph;

   adc_seq_evt u_evt (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en_i),
      .trig_sw  (trig_sw_i),
      .trig_ext (trig_ext_i),
      .trig_tmr (trig_tmr_i),
      .reg_wr   (reg_wr_i),
      .trig_any (trig_any),
      .evt_any  (evt_any),
      .en_rise  (en_rise)
   );

   adc_seq_len #(
      .SPD_W      (SPD_W),
      .CNT_W      (CNT_W),
      .CONV_UNIT  (CONV_UNIT),
      .STAB_STEP  (STAB_STEP),
      .STAB_CAP   (STAB_CAP),
      .WAIT_EXTRA (WAIT_EXTRA)
   ) u_len (
      .code_new (spd_i),
      .code_cur (spd_q),
      .stab_new (stab_new),
      .conv_cur (conv_cur),
      .wait_cur (wait_cur)
   );

   adc_seq_fsm #(
      .SPD_W      (SPD_W),
      .CNT_W      (CNT_W),
      .RESP_LEN   (RESP_LEN),
      .STAB_REINS (STAB_REINS)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en_i),
      .en_rise  (en_rise),
      .trig_any (trig_any),
      .evt_any  (evt_any),
      .spd      (spd_i),
      .stab_new (stab_new),
      .conv_cur (conv_cur),
      .wait_cur (wait_cur),
      .ph       (ph),
      .spd_q    (spd_q),
      .irq      (irq)
   );

   assign phase_o  = ph;
   assign ana_en_o = (ph == PH_CONV);
   assign busy_o   = (ph != PH_IDLE);
   assign irq_o    = irq;

   // R3
   ana_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ana_en_o) |-> ($past(ph) == PH_RESP || $past(ph) == PH_STAB));

   // R12
   busy_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ($past(busy_o) && !busy_o));
endmodule

// File: tb/adc_conv_sequencer_tb.sv
`timescale 1ns/1ps
module adc_conv_sequencer_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [2:0] spd = 3'd0;
   logic       trig_sw = 1'b0, trig_ext = 1'b0, trig_tmr = 1'b0, reg_wr = 1'b0;
   logic [2:0] phase;
   logic       ana_en, busy, irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   adc_conv_sequencer dut_i (
      .clk(clk), .rst_n(rst_n), .en_i(en), .spd_i(spd),
      .trig_sw_i(trig_sw), .trig_ext_i(trig_ext), .trig_tmr_i(trig_tmr),
      .reg_wr_i(reg_wr), .phase_o(phase), .ana_en_o(ana_en),
      .busy_o(busy), .irq_o(irq)
   );

   function automatic int f_stab(input logic [2:0] n);
      return (n < 3) ? 13 * (int'(n) + 1) : 50;
   endfunction
   function automatic int f_conv(input logic [2:0] n);
      return 26 * (int'(n) + 1);
   endfunction
   function automatic int f_total_en(input logic [2:0] n);
      return f_stab(n) + 2 * f_conv(n) + 1;
   endfunction
   function automatic int f_total_trig(input logic [2:0] n);
      return 3 + 2 * f_conv(n) + 1;
   endfunction

   // cycle-level expectation built from the requirements
   logic [2:0] m_ph;
   int         m_cnt;
   logic [2:0] m_spd;
   logic       m_irq, m_en_q;
   wire        m_tg = trig_sw | trig_ext | trig_tmr;
   wire        m_ev = m_tg | reg_wr;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph <= 0; m_cnt <= 0; m_spd <= 0; m_irq <= 0; m_en_q <= 0;
      end else begin
         m_en_q <= en;
         m_irq  <= 0;
         if (!en) m_ph <= 0;
         else if (m_ph == 0) begin
            if (!m_en_q) begin m_ph <= 2; m_cnt <= f_stab(spd) - 1; m_spd <= spd; end
            else if (m_tg) begin m_ph <= 1; m_cnt <= 2; m_spd <= spd; end
         end else if (m_ph == 2) begin
            if (m_cnt == 0) begin
               if (m_ev) m_cnt <= 63;
               else begin m_ph <= 3; m_cnt <= f_conv(m_spd) - 1; end
            end else m_cnt <= m_cnt - 1;
         end else begin
            if (m_ev) begin m_ph <= 1; m_cnt <= 2; m_spd <= spd; end
            else if (m_cnt == 0) begin
               if (m_ph == 1) begin m_ph <= 3; m_cnt <= f_conv(m_spd) - 1; end
               else if (m_ph == 3) begin m_ph <= 4; m_cnt <= f_conv(m_spd); end
               else begin m_ph <= 0; m_irq <= 1; end
            end else m_cnt <= m_cnt - 1;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic string ph_tag(input logic [2:0] p);
      case (p)
         3'd1: return "R5 phase";
         3'd2: return "R7 phase";
         3'd3: return "R3 phase";
         3'd4: return "R4 phase";
         default: return "R10 phase";
      endcase
   endfunction

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
      if (phase !== m_ph) chk(0, ph_tag(m_ph), int'(phase), int'(m_ph));
      else if (ana_en !== (m_ph == 3)) chk(0, "R3 ana_en", int'(ana_en), int'(m_ph == 3));
      else if (busy !== (m_ph != 0)) chk(0, "R12 busy", int'(busy), int'(m_ph != 0));
      else if (irq !== m_irq) chk(0, "R4 irq", int'(irq), int'(m_irq));
      else chk(1, "model", 0, 0);
   endtask

   task automatic clr();
      trig_sw = 0; trig_ext = 0; trig_tmr = 0; reg_wr = 0;
   endtask

   // caller drives the start stimulus; reg_wr is pulsed at ev_a / ev_b
   task automatic timed(input int ev_a, input int ev_b, input logic [2:0] spd2,
                        output int t, output int ana_n);
      t = -1; ana_n = 0;
      for (int c = 1; c <= 2000; c++) begin
         if (c == 2) spd = spd2;
         if (c > 1 && (c == ev_a || c == ev_b)) reg_wr = 1;
         cyc();
         clr();
         if (ana_en) ana_n++;
         if (irq) begin t = c - 1; break; end
      end
   endtask

   task automatic en_cycle(input logic [2:0] n);
      en = 0; cyc(); cyc();
      en = 1; spd = n;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int t, a;
      bit ok;
      void'($urandom(32'h5EED_0A0C));
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(phase == 0 && !ana_en && !busy && !irq, "R1 reset", int'(phase), 0);

      // R2 enable-rise totals
      en_cycle(3'd0); timed(0, 0, 3'd0, t, a);
      chk(t == f_total_en(0) && t == 66, "R2 code0 total", t, 66);
      chk(a == 26, "R3 code0 ana width", a, 26);
      en_cycle(3'd3); timed(0, 0, 3'd3, t, a);
      chk(t == 259, "R2 code3 total", t, f_total_en(3));
      en_cycle(3'd7); timed(0, 0, 3'd7, t, a);
      chk(t == 467, "R2 code7 total", t, f_total_en(7));
      chk(a == 208, "R3 code7 ana width", a, 208);

      // R5 triggers from idle
      cyc();
      trig_sw = 1; spd = 3'd2; timed(0, 0, 3'd2, t, a);
      chk(t == f_total_trig(2), "R5 sw trigger", t, f_total_trig(2));
      chk(a == 78, "R3 code2 ana width", a, 78);
      cyc();
      trig_ext = 1; spd = 3'd5; timed(0, 0, 3'd5, t, a);
      chk(t == f_total_trig(5), "R5 ext trigger", t, f_total_trig(5));
      cyc();
      trig_tmr = 1; spd = 3'd0; timed(0, 0, 3'd0, t, a);
      chk(t == 56, "R5 timer trigger", t, 56);

      // R6 restart during conversion with new code, R11 new code applies
      cyc();
      trig_sw = 1; spd = 3'd1; timed(20, 0, 3'd4, t, a);
      chk(t == 19 + f_total_trig(4), "R6 restart in conversion", t, 19 + f_total_trig(4));
      // R6 restart during wait
      cyc();
      trig_sw = 1; spd = 3'd0; timed(40, 0, 3'd0, t, a);
      chk(t == 39 + f_total_trig(0), "R6 restart in wait", t, 39 + f_total_trig(0));

      // R7 conflict at stabilization end, single and repeated
      en_cycle(3'd0); timed(14, 0, 3'd0, t, a);
      chk(t == 130, "R7 single reinsert", t, 130);
      en_cycle(3'd0); timed(14, 78, 3'd0, t, a);
      chk(t == 194, "R7 double reinsert", t, 194);

      // R8 strobes inside stabilization ignored
      en_cycle(3'd0); timed(5, 0, 3'd0, t, a);
      chk(t == 66, "R8 early strobe", t, 66);
      en_cycle(3'd0); timed(13, 0, 3'd0, t, a);
      chk(t == 66, "R8 strobe one before end", t, 66);

      // R11 code change mid-cycle
      cyc();
      trig_sw = 1; spd = 3'd1; timed(0, 0, 3'd7, t, a);
      chk(t == f_total_trig(1), "R11 trigger cycle", t, f_total_trig(1));
      en_cycle(3'd2); timed(0, 0, 3'd0, t, a);
      chk(t == 196, "R11 enable cycle", t, 196);

      // R9 write in idle
      cyc();
      reg_wr = 1; cyc(); clr();
      ok = 1;
      for (int i = 0; i < 20; i++) begin
         cyc();
         if (phase != 0 || irq) ok = 0;
      end
      chk(ok, "R9 idle write", int'(phase), 0);

      // R10 enable drop mid conversion
      trig_sw = 1; spd = 3'd7; cyc(); clr();
      repeat (30) cyc();
      chk(phase == 3, "R3 in conversion before drop", int'(phase), 3);
      en = 0; cyc();
      chk(phase == 0 && !busy, "R10 drop to idle", int'(phase), 0);
      ok = 1;
      for (int i = 0; i < 500; i++) begin
         cyc();
         if (irq) ok = 0;
      end
      chk(ok, "R10 no interrupt", 1, 0);

      // random mix against the model
      en = 1;
      for (int i = 0; i < 30000; i++) begin
         if ($urandom_range(7) == 0) spd = 3'($urandom_range(7));
         trig_sw  = ($urandom_range(299) == 0);
         trig_ext = ($urandom_range(299) == 0);
         trig_tmr = ($urandom_range(299) == 0);
         reg_wr   = ($urandom_range(199) == 0);
         if (en && $urandom_range(1999) == 0) en = 0;
         else if (!en && $urandom_range(9) == 0) en = 1;
         if (en && phase == 0 && $urandom_range(49) == 0) trig_sw = 1;
         cyc();
         clr();
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule